// File: doc/BRIEF.md
# Serial Receive Byte Queue with Idle Timeout

This block sits behind a serial receiver. It holds incoming bytes in a small first-in first-out store until the processor collects them. Two interrupt lines tell the processor when to read. The fill interrupt is a level that is high while the number of held bytes is at or above a selectable trigger point: a single byte, or half the store. The timeout interrupt covers the case where a message ends with fewer bytes than the trigger point. Without it, those bytes would wait until more traffic arrived.

An idle counter advances on each character-time tick while the queue holds data and nothing happens. It restarts whenever a byte is accepted or the processor reads, and it stays at zero while the queue is empty. When the counter reaches a set number of character times, the timeout interrupt is raised. It stays high until the processor reads or another byte arrives. A byte that arrives when the queue is full is discarded and recorded in a sticky overrun flag. A read from an empty queue changes nothing.

Top module: `rx_timeout_fifo`

## Requirements
- R1: After reset, fillLevel is 0, empty is 1, and thrIrq, toutIrq, overrun and rdData are all 0.
- R2: Bytes are returned in arrival order. rdData presents the oldest held byte on the cycle after a rdStrobe accepted while the queue is not empty. With the default parameters, up to 8 bytes are held.
- R3: fillLevel equals the number of held bytes, and empty is 1 exactly when fillLevel is 0.
- R4: With thrSelHalf at 0, thrIrq is 1 whenever fillLevel is 1 or more.
- R5: With thrSelHalf at 1, thrIrq is 1 only when fillLevel is 4 or more. With 3 bytes held it stays 0 until a fourth byte arrives.
- R6: While the queue holds data and there is no byte and no read, the fourth charTick (IDLE_CHARS) raises toutIrq on that tick's clock edge. Further ticks keep it high.
- R7: The idle count restarts at zero on every accepted byte and every accepted read. It is held at zero while the queue is empty, so ticks on an empty queue never lead to a timeout.
- R8: toutIrq clears on the edge of any cycle with rdStrobe or rxValid high. Clearing takes priority over a tick that would raise it in the same cycle.
- R9: A byte that arrives while the queue holds 8 bytes and no read is made is dropped, and overrun is set. overrun stays set until reset. When a read and a byte fall in the same cycle at full, the byte is accepted and fillLevel stays 8.
- R10: A rdStrobe while empty leaves rdData, fillLevel and the interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Received byte strobe, one cycle per byte |
| charTick | input | 1 | One-cycle pulse per character time |
| thrSelHalf | input | 1 | 0: trigger at 1 byte, 1: trigger at half full |
| rdStrobe | input | 1 | Processor read request |
| rdData | output | 8 | Byte returned by the last accepted read |
| fillLevel | output | 4 | Number of bytes held |
| empty | output | 1 | Queue holds no byte |
| thrIrq | output | 1 | Fill-level interrupt (level) |
| toutIrq | output | 1 | Idle timeout interrupt |
| overrun | output | 1 | Sticky flag for a byte lost to a full queue |

## Verification
Two pairs of events can land in the same cycle. The first pair is a byte arrival and a processor read while the queue is full. The bench drives both strobes on one edge and expects the byte to be kept, the level to stay at 8, the oldest byte to come out, and the new byte to appear last when the queue is drained. The second pair is a timeout tick and a new byte. The bench sends the byte together with the tick that would otherwise be the fourth idle tick. It expects no timeout on that edge, then counts a fresh run of four ticks before the interrupt appears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

endpackage

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop) begin
        rdPtr  <= nextPtr(rdPtr);
        rdData <= mem[rdPtr];
      end
    end
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int IDLE_CHARS = 4,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rdStrobe,
  input  logic             charTick,
  input  logic             thrSelHalf,
  output qStrobe_t         strobe,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             thrIrq,
  output logic             toutIrq,
  output logic             overrun
);

  localparam int IDLE_W = $clog2(IDLE_CHARS + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(IDLE_CHARS);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CHARS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0]  HALF_CNT  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0]  ONE_CNT   = CNT_W'(1);

  logic [IDLE_W-1:0] idleCnt;
  logic              full;

  assign empty      = (count == '0);
  assign full       = (count == FULL_CNT);
  assign strobe.pop = rdStrobe && !empty;
  assign strobe.push = rxValid && (!full || strobe.pop);
  assign thrIrq     = (count >= (thrSelHalf ? HALF_CNT : ONE_CNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      idleCnt <= '0;
      toutIrq <= 1'b0;
      overrun <= 1'b0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase

      if (rxValid && !strobe.push) overrun <= 1'b1;

      if (strobe.push || strobe.pop || empty) idleCnt <= '0;
      else if (charTick && idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;

      if (rdStrobe || rxValid) toutIrq <= 1'b0;
      else if (charTick && !empty && idleCnt == IDLE_LAST) toutIrq <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_timeout_fifo.sv
module rx_timeout_fifo
  import rxq_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int DEPTH      = 8,
  parameter int IDLE_CHARS = 4,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rxData,
  input  logic             rxValid,
  input  logic             charTick,
  input  logic             thrSelHalf,
  input  logic             rdStrobe,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] fillLevel,
  output logic             empty,
  output logic             thrIrq,
  output logic             toutIrq,
  output logic             overrun
);

  qStrobe_t strobe;

  rxq_ctrl #(.DEPTH(DEPTH), .IDLE_CHARS(IDLE_CHARS)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rdStrobe(rdStrobe),
    .charTick(charTick), .thrSelHalf(thrSelHalf), .strobe(strobe),
    .count(fillLevel), .empty(empty), .thrIrq(thrIrq),
    .toutIrq(toutIrq), .overrun(overrun)
  );

  rxq_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(rxData), .rdData(rdData)
  );

endmodule

// File: rtl/rx_timeout_fifo_chk.sv
module rx_timeout_fifo_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             thrSelHalf,
  input logic             rdStrobe,
  input logic [WIDTH-1:0] rdData,
  input logic [CNT_W-1:0] fillLevel,
  input logic             empty,
  input logic             thrIrq,
  input logic             toutIrq,
  input logic             overrun
);

  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= DEPTH);

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rdStrobe && fillLevel < DEPTH |=> fillLevel == $past(fillLevel) + 1'b1);

  a_r5_half_needs_four: assert property (@(posedge clk) disable iff (!rstN)
    thrSelHalf && fillLevel < DEPTH / 2 |-> !thrIrq);

  a_r6_tout_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    toutIrq |-> !empty);

  a_r8_read_clears_tout: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !toutIrq);

  a_r8_byte_clears_tout: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !toutIrq);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  a_r10_empty_read_inert: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !rxValid && empty |=> $stable(rdData) && $stable(fillLevel));

endmodule

bind rx_timeout_fifo rx_timeout_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .thrSelHalf(thrSelHalf),
  .rdStrobe(rdStrobe), .rdData(rdData), .fillLevel(fillLevel), .empty(empty),
  .thrIrq(thrIrq), .toutIrq(toutIrq), .overrun(overrun)
);

// File: tb/test_rx_timeout_fifo.sv
`timescale 1ns/1ps
module test_rx_timeout_fifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxValid = 1'b0;
  logic       charTick = 1'b0;
  logic       thrSelHalf = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic [3:0] fillLevel;
  logic       empty, thrIrq, toutIrq, overrun;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rx_timeout_fifo i_rx_timeout_fifo (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid),
    .charTick(charTick), .thrSelHalf(thrSelHalf), .rdStrobe(rdStrobe),
    .rdData(rdData), .fillLevel(fillLevel), .empty(empty),
    .thrIrq(thrIrq), .toutIrq(toutIrq), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic t, input logic r);
    rxValid = v; rxData = d; charTick = t; rdStrobe = r;
    @(posedge clk); #1;
    rxValid = 1'b0; charTick = 1'b0; rdStrobe = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int lvl;
    #12; rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 level", fillLevel, 0);
    chk("R1 empty", empty, 1);
    chk("R1 thrIrq", thrIrq, 0);
    chk("R1 toutIrq", toutIrq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rdData", rdData, 0);

    // R4 / R3: fill to full with trigger at one byte
    thrSelHalf = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc(1, 8'h10 + 8'(i), 0, 0);
      chk("R3 level", fillLevel, i + 1);
      chk("R3 empty", empty, 0);
      chk("R4 thrIrq one", thrIrq, 1);
    end
    chk("R9 no overrun yet", overrun, 0);
    cyc(1, 8'h99, 0, 0);
    chk("R9 drop level", fillLevel, 8);
    chk("R9 overrun set", overrun, 1);
    // R9 read and byte together at full
    cyc(1, 8'hEE, 0, 1);
    chk("R9 simul level", fillLevel, 8);
    chk("R2 first byte", rdData, 8'h10);
    // R2 drain in order
    for (int i = 1; i < 9; i++) begin
      cyc(0, 0, 0, 1);
      chk("R2 order", rdData, (i < 8) ? 8'h10 + 8'(i) : 8'hEE);
      chk("R3 level drain", fillLevel, 8 - i);
      chk("R4 thrIrq drain", thrIrq, (8 - i) >= 1);
    end
    chk("R3 empty after drain", empty, 1);
    // R10 empty read
    cyc(0, 0, 0, 1);
    chk("R10 rdData kept", rdData, 8'hEE);
    chk("R10 level kept", fillLevel, 0);
    chk("R10 thrIrq kept", thrIrq, 0);
    chk("R10 toutIrq kept", toutIrq, 0);

    // R5 half trigger sweep
    thrSelHalf = 1'b1;
    #1;
    chk("R5 zero", thrIrq, 0);
    for (int i = 1; i <= 8; i++) begin
      cyc(1, 8'h40 + 8'(i), 0, 0);
      chk("R5 half trigger", thrIrq, i >= 4);
    end
    lvl = 8;
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 0, 1);
      lvl--;
      chk("R5 half drain", thrIrq, lvl >= 4);
      chk("R2 order half", rdData, 8'h41 + 8'(i));
    end
    thrSelHalf = 1'b0;

    // R6 timeout after four idle ticks
    cyc(1, 8'hA1, 0, 0);
    cyc(1, 8'hA2, 0, 0);
    for (int i = 1; i <= 4; i++) begin
      cyc(0, 0, 1, 0);
      chk("R6 tout tick", toutIrq, i == 4);
    end
    cyc(0, 0, 1, 0);
    chk("R6 tout holds", toutIrq, 1);
    // R8 read clears
    cyc(0, 0, 0, 1);
    chk("R8 read clears", toutIrq, 0);
    chk("R2 tout data", rdData, 8'hA1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
    chk("R7 restart after read", toutIrq, 0);
    // R8 byte together with the would-be fourth tick
    cyc(1, 8'hA3, 1, 0);
    chk("R8 clear beats set", toutIrq, 0);
    for (int i = 1; i <= 4; i++) begin
      cyc(0, 0, 1, 0);
      chk("R7 restart after byte", toutIrq, i == 4);
    end
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk("R2 tail", rdData, 8'hA3);
    chk("R3 empty again", empty, 1);
    // R7 ticks on empty queue do nothing
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 1, 0);
      chk("R7 empty idle", toutIrq, 0);
    end
    cyc(1, 8'hB0, 0, 0);
    for (int i = 1; i <= 4; i++) begin
      cyc(0, 0, 1, 0);
      chk("R7 counter was zero", toutIrq, i == 4);
    end
    cyc(0, 0, 0, 1);
    chk("R8 final clear", toutIrq, 0);
    chk("R9 overrun still set", overrun, 1);

    summary();
    $finish;
  end

endmodule